// File: doc/BRIEF.md
# Smart Card Character Transmitter with Automatic Repeat

This block sends bytes over a half-duplex smart card I/O line. Each byte becomes a character of ten bits: one low start bit, the eight data bits least significant first, and an even parity bit. The line is open-drain. The block only pulls it low, and an external pull-up or the card holds it high otherwise. Bit timing comes from an input strobe that fires twice per elementary time unit (ETU), so every bit lasts two strobes.

When a character has gone out, the block releases the line. It then looks for the card's error signal, which is the card pulling the line low just after the parity bit. If the card signals an error, the block raises an error flag and resends the same byte with no software action. It waits until the card has let go of the line and a guard gap has passed before it starts again. If the card signals no error, the block reports the character as done. A mode bit picks when that happens: 12.5 ETU after the start bit, or 11.0 ETU in the short mode.

Software loads a byte through a one-strobe write port. It watches the data-empty, transmit-done and error flags, or uses the two level interrupt requests built from them. The caller must synchronise the line input to the clock before it reaches the block.

Top module: `sc_char_tx`

## Requirements
- R1: After reset, data_empty and tx_done are 1, err_flag is 0, line_drive_low is 0, and both interrupt outputs are 0.
- R2: The character is sent as follows:
  - The start bit begins on the first half_tick after an accepted write.
  - line_drive_low is 1 while the current bit is 0.
  - The bit order is: start bit (0), then wr_data bit 0 up to bit 7, then parity equal to the XOR of the eight data bits.
  - Each bit lasts two half_ticks.
  - The line is released after the parity bit.
- R3: A write is accepted only when tx_enable is 1, data_empty is 1 and err_flag is 0. An accepted write clears data_empty and tx_done. Any other write starts no character and changes no flag.
- R4: With short_end at 0 and no card error, tx_done and data_empty become 1 on the 25th half_tick after the start-bit half_tick (12.5 ETU), and not before.
- R5: With short_end at 1 and no card error, tx_done and data_empty become 1 on the 22nd half_tick after the start-bit half_tick (11.0 ETU), and not before.
- R6: The line is sampled on the 22nd half_tick after the start bit. If it is low there, err_flag is set, tx_done stays 0, and the block keeps the line released.
- R7: After a card error, the block waits for the first half_tick at which the line is high again. The repeated start bit begins on the fourth half_tick after that one and carries the same byte. Every further error repeats the same sequence.
- R8: err_flag stays 1 until a cycle with err_clr at 1. That clear takes effect on the next clock edge. A new card error takes priority over a clear in the same cycle.
- R9: empty_irq equals tx_done AND empty_irq_en. error_irq equals err_flag AND error_irq_en.
- R10: When tx_enable is 0, line_drive_low is 0 from the next clock edge. data_empty and tx_done also become 1 at that edge, and no character starts while tx_enable stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| half_tick | input | 1 | One-cycle strobe, two per elementary time unit |
| tx_enable | input | 1 | Transmit enable; 0 aborts and idles the block |
| short_end | input | 1 | Mode bit: 1 ends a character at 11.0 ETU, 0 at 12.5 ETU |
| empty_irq_en | input | 1 | Enable for the data-empty interrupt |
| error_irq_en | input | 1 | Enable for the error interrupt |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | 8 | Byte to transmit |
| err_clr | input | 1 | Clear strobe for the error flag |
| line_in | input | 1 | Synchronised level of the I/O line |
| line_drive_low | output | 1 | Pull the I/O line low when 1 |
| data_empty | output | 1 | Data register may be written |
| tx_done | output | 1 | Last character finished without error |
| err_flag | output | 1 | The card signalled an error |
| empty_irq | output | 1 | Data-empty interrupt request |
| error_irq | output | 1 | Error interrupt request |

## Verification
The hard case to reach is the repeat path. The card's error pulse must land inside the half-ETU window just before the sampling strobe. The line must then stay low across several strobes and be released at a known tick, so that the guard gap to the repeated start bit can be counted exactly.

The bench includes a card model that tracks the transmitter's start bit against a running half_tick count. The model decodes every character and pulls the line low from the 21st to the 25th half_tick of a frame. A budget sets how many frames in a row receive an error, so single and back-to-back repeats are driven in both end-timing modes.

// File: rtl/sc_char_pkg.sv
package sc_char_pkg;
  // Sequencer states of the character transmitter
  typedef enum logic [2:0] {
    ST_IDLE,   // nothing to send
    ST_PEND,   // byte accepted, waiting for the next half tick
    ST_SEND,   // character bits and end window in progress
    ST_ERRW,   // card holds the error signal
    ST_GUARD   // gap before the repeated character
  } seq_state_e;
endpackage

// File: rtl/sc_char_seq.sv
module sc_char_seq
  import sc_char_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int GUARD_HALVES = 4,
  localparam int FRAME_BITS   = DATA_W + 2,
  localparam int FRAME_HALVES = 2 * FRAME_BITS,
  localparam int SAMPLE_AT    = FRAME_HALVES + 1,
  localparam int NORMAL_AT    = FRAME_HALVES + 4,
  localparam int CNT_W        = $clog2(NORMAL_AT + 1),
  localparam int G_W          = $clog2(GUARD_HALVES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_tick,
  input  logic             enable,
  input  logic             short_end,
  input  logic             start_req,
  input  logic             line_in,
  output logic             sending,
  output logic [CNT_W-1:0] hcnt,
  output logic             char_ok,
  output logic             err_evt
);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] hcnt_q, hcnt_d;
  logic [G_W-1:0]   gcnt_q, gcnt_d;

  always_comb begin
    state_d = state_q;
    hcnt_d  = hcnt_q;
    gcnt_d  = gcnt_q;
    char_ok = 1'b0;
    err_evt = 1'b0;
    if (!enable) begin
      state_d = ST_IDLE;
      hcnt_d  = '0;
      gcnt_d  = '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_req) state_d = ST_PEND;
        ST_PEND: if (half_tick) begin
          state_d = ST_SEND;
          hcnt_d  = '0;
        end
        ST_SEND: if (half_tick) begin
          hcnt_d = hcnt_q + 1'b1;
          if (hcnt_q == CNT_W'(SAMPLE_AT)) begin
            if (!line_in) begin
              err_evt = 1'b1;
              state_d = ST_ERRW;
            end else if (short_end) begin
              char_ok = 1'b1;
              state_d = ST_IDLE;
            end
          end else if (hcnt_q == CNT_W'(NORMAL_AT)) begin
            char_ok = 1'b1;
            state_d = ST_IDLE;
          end
        end
        ST_ERRW: if (half_tick && line_in) begin
          state_d = ST_GUARD;
          gcnt_d  = '0;
        end
        ST_GUARD: if (half_tick) begin
          if (gcnt_q == G_W'(GUARD_HALVES - 1)) begin
            state_d = ST_SEND;
            hcnt_d  = '0;
          end else begin
            gcnt_d = gcnt_q + 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hcnt_q  <= '0;
      gcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      hcnt_q  <= hcnt_d;
      gcnt_q  <= gcnt_d;
    end
  end

  assign sending = (state_q == ST_SEND);
  assign hcnt    = hcnt_q;

endmodule

// File: rtl/sc_char_shifter.sv
module sc_char_shifter #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5,
  localparam int FRAME_BITS = DATA_W + 2
) (
  input  logic              sending,
  input  logic [CNT_W-1:0]  hcnt,
  input  logic [DATA_W-1:0] data,
  output logic              drive_low
);

  logic [FRAME_BITS-1:0] frame_vec;
  logic [CNT_W-1:0]      bit_idx;
  logic [FRAME_BITS-1:0] low_hit;

  // start bit at index 0, even parity on top
  assign frame_vec = {^data, data, 1'b0};
  assign bit_idx   = hcnt >> 1;

  for (genvar i = 0; i < FRAME_BITS; i++) begin : g_bit
    assign low_hit[i] = (bit_idx == CNT_W'(i)) & ~frame_vec[i];
  end

  assign drive_low = sending & (|low_hit);

endmodule

// File: rtl/sc_char_status.sv
module sc_char_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              err_clr,
  input  logic              char_ok,
  input  logic              err_evt,
  input  logic              empty_irq_en,
  input  logic              error_irq_en,
  output logic [DATA_W-1:0] data_q,
  output logic              empty_q,
  output logic              done_q,
  output logic              err_q,
  output logic              start_req,
  output logic              empty_irq,
  output logic              error_irq
);

  logic accept;
  logic empty_d, done_d, err_d;

  assign accept    = wr_en & enable & empty_q & ~err_q;
  assign start_req = accept;

  always_comb begin
    empty_d = empty_q;
    done_d  = done_q;
    if (!enable || char_ok) begin
      empty_d = 1'b1;
      done_d  = 1'b1;
    end else if (accept) begin
      empty_d = 1'b0;
      done_d  = 1'b0;
    end
    err_d = err_q;
    if (err_evt)      err_d = 1'b1;
    else if (err_clr) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      empty_q <= 1'b1;
      done_q  <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      if (accept) data_q <= wr_data;
      empty_q <= empty_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign empty_irq = done_q & empty_irq_en;
  assign error_irq = err_q & error_irq_en;

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clr) |=> err_q);

  // R4
  flag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> empty_q);

endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx #(
  parameter int DATA_W       = 8,
  parameter int GUARD_HALVES = 4,
  localparam int FRAME_BITS  = DATA_W + 2,
  localparam int CNT_W       = $clog2(2 * FRAME_BITS + 5)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_tick,
  input  logic              tx_enable,
  input  logic              short_end,
  input  logic              empty_irq_en,
  input  logic              error_irq_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              err_clr,
  input  logic              line_in,
  output logic              line_drive_low,
  output logic              data_empty,
  output logic              tx_done,
  output logic              err_flag,
  output logic              empty_irq,
  output logic              error_irq
);

  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic              sending, char_ok, err_evt, start_req;
  logic [CNT_W-1:0]  hcnt;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  sc_char_seq #(.DATA_W(DATA_W), .GUARD_HALVES(GUARD_HALVES)) seq_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .half_tick (half_tick),
    .enable    (tx_enable),
    .short_end (short_end),
    .start_req (start_req),
    .line_in   (line_in),
    .sending   (sending),
    .hcnt      (hcnt),
    .char_ok   (char_ok),
    .err_evt   (err_evt)
  );

  sc_char_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) shift_i (
    .sending   (sending),
    .hcnt      (hcnt),
    .data      (data_q),
    .drive_low (line_drive_low)
  );

  sc_char_status #(.DATA_W(DATA_W)) stat_i (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .enable       (tx_enable),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .err_clr      (err_clr),
    .char_ok      (char_ok),
    .err_evt      (err_evt),
    .empty_irq_en (empty_irq_en),
    .error_irq_en (error_irq_en),
    .data_q       (data_q),
    .empty_q      (data_empty),
    .done_q       (tx_done),
    .err_q        (err_flag),
    .start_req    (start_req),
    .empty_irq    (empty_irq),
    .error_irq    (error_irq)
  );

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sending && hcnt == '0) |-> line_drive_low);

  // R6
  release_on_err_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(err_flag) |-> !line_drive_low);

  // R10
  enable_abort_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !tx_enable |=> (!line_drive_low && data_empty && tx_done));

endmodule

// File: tb/sc_char_tx_tb_top.sv
module sc_char_tx_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] cyc = '0;
  logic        half_tick;
  int          tick_cnt = 0;
  always @(negedge clk) cyc <= cyc + 1;
  assign half_tick = (cyc[1:0] == 2'b11);
  always @(posedge clk) if (half_tick) tick_cnt <= tick_cnt + 1;

  logic       tx_enable, short_end, empty_irq_en, error_irq_en;
  logic       wr_en, err_clr, card_low;
  logic [7:0] wr_data;
  logic       line_drive_low, data_empty, tx_done, err_flag, empty_irq, error_irq;
  logic       line;
  assign line = ~(line_drive_low | card_low);

  sc_char_tx dut_i (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .tx_enable(tx_enable),
    .short_end(short_end), .empty_irq_en(empty_irq_en), .error_irq_en(error_irq_en),
    .wr_en(wr_en), .wr_data(wr_data), .err_clr(err_clr), .line_in(line),
    .line_drive_low(line_drive_low), .data_empty(data_empty), .tx_done(tx_done),
    .err_flag(err_flag), .empty_irq(empty_irq), .error_irq(error_irq)
  );

  int n_checks = 0;
  int n_err = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic wait_tick(input int t);
    while (tick_cnt < t) @(negedge clk);
  endtask

  // card model: decodes characters, pulls the line low for error frames
  int         frames_seen = 0;
  int         err_budget = 0;
  logic [7:0] last_byte;
  logic       last_par_ok;
  int         cs;
  logic [9:0] cbits;
  logic       prev_drv;
  initial begin
    prev_drv = 1'b0;
    card_low = 1'b0;
    forever begin
      @(negedge clk);
      if (line_drive_low && !prev_drv) begin
        cs = tick_cnt;
        for (int i = 0; i < 10; i++) begin
          wait_tick(cs + 2 * i + 1);
          cbits[i] = line;
        end
        last_byte   = cbits[8:1];
        last_par_ok = (cbits[0] == 1'b0) && (cbits[9] == ^cbits[8:1]);
        frames_seen++;
        if (err_budget > 0) begin
          err_budget--;
          wait_tick(cs + 21);
          card_low = 1'b1;
          wait_tick(cs + 25);
          card_low = 1'b0;
        end
      end
      prev_drv = line_drive_low;
    end
  end

  task automatic do_write(input logic [7:0] d, output int w);
    @(negedge clk); #1;
    while (cyc[1:0] == 2'b11) begin @(negedge clk); #1; end
    wr_data = d;
    wr_en = 1'b1;
    w = tick_cnt;
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "data_empty", data_empty, 1);
    chk("R1", "tx_done", tx_done, 1);
    chk("R1", "err_flag", err_flag, 0);
    chk("R1", "line drive", line_drive_low, 0);
    chk("R1", "irqs", {empty_irq, error_irq}, 0);
  endtask

  task automatic t_frame(input logic mode, input logic [7:0] d);
    int w, s, f0, e;
    short_end = mode;
    f0 = frames_seen;
    e = mode ? 22 : 25;
    do_write(d, w);
    s = w + 1;
    chk("R3", "data_empty cleared", data_empty, 0);
    chk("R3", "tx_done cleared", tx_done, 0);
    wait_tick(s);
    chk("R2", "start bit on first tick", line_drive_low, 1);
    wait_tick(s + e - 1);
    chk(mode ? "R5" : "R4", "done not early", tx_done, 0);
    wait_tick(s + e);
    chk(mode ? "R5" : "R4", "done on time", tx_done, 1);
    chk(mode ? "R5" : "R4", "empty on time", data_empty, 1);
    chk("R2", "decoded byte", last_byte, d);
    chk("R2", "start and parity", last_par_ok, 1);
    chk("R2", "one frame", frames_seen - f0, 1);
  endtask

  task automatic t_ignored();
    int w, s, f0;
    short_end = 1'b0;
    f0 = frames_seen;
    do_write(8'h5A, w);
    s = w + 1;
    wait_tick(s + 4);
    @(negedge clk); #1;
    wr_data = 8'hFF; wr_en = 1'b1;
    @(negedge clk); #1;
    wr_en = 1'b0;
    chk("R3", "busy write leaves empty low", data_empty, 0);
    wait_tick(s + 25);
    wait_tick(s + 60);
    chk("R3", "busy write no frame", frames_seen - f0, 1);
    chk("R3", "busy write no data change", last_byte, 8'h5A);
    tx_enable = 1'b0;
    f0 = frames_seen;
    do_write(8'h33, w);
    wait_tick(w + 12);
    chk("R3", "disabled write no frame", frames_seen - f0, 0);
    chk("R3", "disabled write empty kept", data_empty, 1);
    tx_enable = 1'b1;
  endtask

  task automatic t_error(input logic mode, input int n, input logic [7:0] d);
    int w, s, f0, e;
    short_end = mode;
    error_irq_en = 1'b1;
    e = mode ? 22 : 25;
    f0 = frames_seen;
    err_budget = n;
    do_write(d, w);
    s = w + 1;
    wait_tick(s + 22);
    chk("R6", "err flag set", err_flag, 1);
    chk("R6", "done held low", tx_done, 0);
    chk("R6", "line released", line_drive_low, 0);
    chk("R9", "error irq", error_irq, 1);
    for (int k = 1; k <= n; k++) begin
      wait_tick(s + 30 * k - 1);
      chk("R7", "quiet before repeat", line_drive_low, 0);
      wait_tick(s + 30 * k);
      chk("R7", "repeat start bit", line_drive_low, 1);
    end
    wait_tick(s + 30 * n + e - 1);
    chk(mode ? "R5" : "R4", "repeat not done early", tx_done, 0);
    wait_tick(s + 30 * n + e);
    chk(mode ? "R5" : "R4", "done after repeat", tx_done, 1);
    chk("R7", "frame count", frames_seen - f0, n + 1);
    chk("R7", "repeated byte", last_byte, d);
    chk("R8", "err flag kept", err_flag, 1);
    f0 = frames_seen;
    do_write(8'hC3, w);
    wait_tick(w + 12);
    chk("R3", "write refused while err", frames_seen - f0, 0);
    chk("R3", "empty kept while err", data_empty, 1);
    @(negedge clk); #1;
    err_clr = 1'b1;
    @(negedge clk); #1;
    err_clr = 1'b0;
    chk("R8", "err cleared", err_flag, 0);
    chk("R9", "error irq off", error_irq, 0);
  endtask

  task automatic t_irq();
    int w;
    @(negedge clk); #1;
    empty_irq_en = 1'b1;
    #1 chk("R9", "empty irq on", empty_irq, 1);
    empty_irq_en = 1'b0;
    #1 chk("R9", "empty irq masked", empty_irq, 0);
    empty_irq_en = 1'b1;
    short_end = 1'b1;
    do_write(8'h0F, w);
    chk("R9", "empty irq low in frame", empty_irq, 0);
    wait_tick(w + 23);
    chk("R9", "empty irq after frame", empty_irq, 1);
  endtask

  task automatic t_abort();
    int w, s, bad;
    short_end = 1'b0;
    do_write(8'h00, w);
    s = w + 1;
    wait_tick(s + 6);
    @(negedge clk); #1;
    tx_enable = 1'b0;
    @(negedge clk);
    chk("R10", "line released", line_drive_low, 0);
    chk("R10", "flags set", {data_empty, tx_done}, 2'b11);
    bad = 0;
    for (int i = 0; i < 160; i++) begin
      @(negedge clk);
      if (line_drive_low) bad++;
    end
    chk("R10", "no drive while disabled", bad, 0);
    tx_enable = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    tx_enable = 1'b1; short_end = 1'b0; empty_irq_en = 1'b0; error_irq_en = 1'b0;
    wr_en = 1'b0; wr_data = '0; err_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_frame(1'b0, 8'hA5);
    t_frame(1'b1, 8'h3C);
    t_frame(1'b0, 8'h80);
    t_ignored();
    t_error(1'b0, 1, 8'h96);
    t_error(1'b1, 2, 8'h71);
    t_irq();
    t_abort();
    t_frame(1'b1, 8'hE1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule